// File: doc/BRIEF.md
# Combined Global and Local History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It draws on two kinds of history. The first is one shared shift register holding the most recent outcomes of all branches, which captures correlation between different branches. The second is a table of per-branch shift registers, selected by address, which captures the branch's own recent pattern. The two histories are joined side by side to address a table of 2-bit saturating counters. Each counter therefore learns how the branch behaves for one particular pairing of a global pattern and a local pattern.

A front end presents a branch address on the lookup stream and receives the predicted direction in the same cycle. When the branch resolves, the back end sends its address and real outcome on the update stream. The block then trains the counter chosen by the pre-update histories and shifts the outcome into the global register and into the branch's local register. A compile-time switch picks one of two ways to form the global half of the index. It can use the global history as it is, or XOR it with address bits to spread unrelated branches apart.

Both streams use valid/ready. Lookup has no ready: the response valid follows the request valid combinationally, and nothing is held. The update ready output is always high, so an update is accepted in every cycle where its valid is high, and the block never applies back-pressure.

Top module: `gl_hist_predictor`

## Requirements
- R1: After reset, every counter holds 01, and the global register and all local registers hold zero. Every lookup therefore returns not-taken until the first update.
- R2: While lk_valid is high, pred_taken equals bit 1 of the addressed counter: states 10 and 11 predict taken, 00 and 01 predict not-taken. While lk_valid is low, pred_taken is 0.
- R3: An accepted taken update raises the addressed counter by one, and the counter stays at 11 once it gets there.
- R4: An accepted not-taken update lowers the addressed counter by one, and the counter stays at 00 once it gets there.
- R5: An accepted update shifts its outcome into bit 0 of the global register and drops the oldest bit. Without an accepted update, the register keeps its value.
- R6: The local register used by an address is selected by address bits [ALIGN_BITS +: log2(LHT_ENTRIES)]. Addresses that agree in those bits share one register. An accepted update shifts its outcome into bit 0 of that register only.
- R7: The counter index is {global part, local history}, with the global part in the upper GHIST_W bits. The global part is the global register when XOR_HASH is 0. When XOR_HASH is 1, it is the global register XOR address bits [ALIGN_BITS +: GHIST_W].
- R8: An update trains the counter whose index is formed from the histories as they stood before that update's own shift.
- R9: A lookup made in the same cycle as an update sees the counters and histories from before that update.
- R10: upd_ready is high whenever rst_n is high, and pred_valid equals lk_valid in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_addr | input | ADDR_W | Branch address to predict |
| pred_valid | output | 1 | Prediction valid, same cycle as the request |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | Resolved branch valid |
| upd_ready | output | 1 | Update accepted; always high out of reset |
| upd_addr | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The bench builds the block with 4 global bits, 4 local bits, 16 local registers, 2 alignment bits, a 16-bit address and XOR hashing on. This gives a 256-counter table. A few thousand updates visit most of that table, and repeated lookups cycle through all 16 local registers. The XOR mode is the harder of the two index forms, because address bits then also change the global half of the index. A hand-worked training sequence fixes the expected counters and histories for saturation, aliasing and pre-update indexing. A mixed random and loop-patterned stream is then compared against an arithmetic model of the index and counters.

// File: rtl/gl_bp_pkg.sv
package gl_bp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_INIT = 2'b01;
  localparam ctr_t CTR_MAX  = 2'b11;
  localparam ctr_t CTR_MIN  = 2'b00;

  // Saturating step of a 2-bit direction counter.
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == CTR_MAX) ? CTR_MAX : ctr_t'(cur + 2'b01);
    else       nxt = (cur == CTR_MIN) ? CTR_MIN : ctr_t'(cur - 2'b01);
    return nxt;
  endfunction

endpackage

// File: rtl/gl_bp_ghr.sv
module gl_bp_ghr #(
  parameter int G = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [G-1:0] hist_o
);

  logic [G-1:0] hist_q;
  logic [G-1:0] hist_d;

  generate
    if (G == 1) begin : g_one
      assign hist_d = bit_in;
    end else begin : g_many
      assign hist_d = {hist_q[G-2:0], bit_in};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)        hist_q <= '0;
    else if (shift_en) hist_q <= hist_d;
  end

  assign hist_o = hist_q;

endmodule

// File: rtl/gl_bp_lht.sv
module gl_bp_lht #(
  parameter int E     = 64,
  parameter int P     = 4,
  localparam int SW   = $clog2(E)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] rd_sel_a,
  output logic [P-1:0]  rd_hist_a,
  input  logic [SW-1:0] rd_sel_b,
  output logic [P-1:0]  rd_hist_b,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic          wr_bit
);

  logic [P-1:0] hist_q [E];
  logic [P-1:0] wr_cur;
  logic [P-1:0] wr_nxt;

  assign wr_cur = hist_q[wr_sel];

  generate
    if (P == 1) begin : g_one
      assign wr_nxt = wr_bit;
    end else begin : g_many
      assign wr_nxt = {wr_cur[P-2:0], wr_bit};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < E; i++) hist_q[i] <= '0;
    end else if (wr_en) begin
      hist_q[wr_sel] <= wr_nxt;
    end
  end

  assign rd_hist_a = hist_q[rd_sel_a];
  assign rd_hist_b = hist_q[rd_sel_b];

endmodule

// File: rtl/gl_bp_index.sv
module gl_bp_index #(
  parameter int G       = 6,
  parameter int P       = 4,
  parameter bit XOR_HASH = 1'b1,
  localparam int IW     = G + P
) (
  input  logic [G-1:0]  ghist,
  input  logic [G-1:0]  hash_bits,
  input  logic [P-1:0]  lhist,
  output logic [IW-1:0] idx
);

  logic [G-1:0] gpart;

  generate
    if (XOR_HASH) begin : g_xor
      assign gpart = ghist ^ hash_bits;
    end else begin : g_plain
      logic unused_hash;
      assign unused_hash = ^hash_bits;
      assign gpart = ghist;
    end
  endgenerate

  assign idx = {gpart, lhist};

endmodule

// File: rtl/gl_bp_pht.sv
module gl_bp_pht
  import gl_bp_pkg::*;
#(
  parameter int IW   = 10,
  localparam int NUM = 1 << IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx,
  output ctr_t          rd_ctr,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_taken,
  output ctr_t          wr_cur,
  output ctr_t          wr_nxt
);

  ctr_t ctr_q [NUM];

  assign rd_ctr = ctr_q[rd_idx];
  assign wr_cur = ctr_q[wr_idx];
  assign wr_nxt = ctr_step(wr_cur, wr_taken);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM; i++) ctr_q[i] <= CTR_INIT;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= wr_nxt;
    end
  end

endmodule

// File: rtl/gl_hist_predictor.sv
module gl_hist_predictor
  import gl_bp_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int GHIST_W     = 6,
  parameter int LHIST_W     = 4,
  parameter int LHT_ENTRIES = 64,
  parameter int ALIGN_BITS  = 2,
  parameter bit XOR_HASH    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              pred_valid,
  output logic              pred_taken,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              upd_taken
);

  localparam int LSEL_W = $clog2(LHT_ENTRIES);
  localparam int IDX_W  = GHIST_W + LHIST_W;

  logic               upd_fire;
  logic [GHIST_W-1:0] ghist_q;
  logic [LSEL_W-1:0]  lk_lsel, up_lsel;
  logic [LHIST_W-1:0] lk_lhist, up_lhist;
  logic [IDX_W-1:0]   lk_idx, up_idx;
  ctr_t               lk_ctr, upd_ctr_cur, upd_ctr_nxt;
  logic               unused_addr;

  assign upd_ready = rst_n;
  assign upd_fire  = upd_valid & upd_ready;

  assign lk_lsel = lk_addr[ALIGN_BITS +: LSEL_W];
  assign up_lsel = upd_addr[ALIGN_BITS +: LSEL_W];
  assign unused_addr = ^{lk_addr, upd_addr};

  gl_bp_ghr #(.G(GHIST_W)) u_ghr (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (upd_fire),
    .bit_in   (upd_taken),
    .hist_o   (ghist_q)
  );

  gl_bp_lht #(.E(LHT_ENTRIES), .P(LHIST_W)) u_lht (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_sel_a  (lk_lsel),
    .rd_hist_a (lk_lhist),
    .rd_sel_b  (up_lsel),
    .rd_hist_b (up_lhist),
    .wr_en     (upd_fire),
    .wr_sel    (up_lsel),
    .wr_bit    (upd_taken)
  );

  gl_bp_index #(.G(GHIST_W), .P(LHIST_W), .XOR_HASH(XOR_HASH)) u_lk_index (
    .ghist     (ghist_q),
    .hash_bits (lk_addr[ALIGN_BITS +: GHIST_W]),
    .lhist     (lk_lhist),
    .idx       (lk_idx)
  );

  gl_bp_index #(.G(GHIST_W), .P(LHIST_W), .XOR_HASH(XOR_HASH)) u_up_index (
    .ghist     (ghist_q),
    .hash_bits (upd_addr[ALIGN_BITS +: GHIST_W]),
    .lhist     (up_lhist),
    .idx       (up_idx)
  );

  gl_bp_pht #(.IW(IDX_W)) u_pht (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (lk_idx),
    .rd_ctr   (lk_ctr),
    .wr_en    (upd_fire),
    .wr_idx   (up_idx),
    .wr_taken (upd_taken),
    .wr_cur   (upd_ctr_cur),
    .wr_nxt   (upd_ctr_nxt)
  );

  assign pred_valid = lk_valid;
  assign pred_taken = lk_valid & lk_ctr[1];

endmodule

// File: rtl/gl_hist_predictor_chk.sv
module gl_hist_predictor_chk #(
  parameter int G = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         upd_valid,
  input logic         upd_ready,
  input logic         upd_taken,
  input logic [G-1:0] ghist,
  input logic [1:0]   upd_cur,
  input logic [1:0]   upd_nxt
);

  logic fire;
  assign fire = upd_valid & upd_ready;

  // R5: accepted outcome enters bit 0, older bits move up
  p_ghr_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (ghist[0] == $past(upd_taken)) && (ghist[G-1:1] == $past(ghist[G-2:0])));

  // R5: no accepted update, no change
  p_ghr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(ghist));

  // R3: taken never lowers the counter and never leaves it at 00
  p_ctr_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && upd_taken) |-> (upd_nxt >= upd_cur) && (upd_nxt != 2'b00));

  // R3: saturation at the top
  p_ctr_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && upd_taken && upd_cur == 2'b11) |-> upd_nxt == 2'b11);

  // R4: not-taken never raises the counter and never leaves it at 11
  p_ctr_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !upd_taken) |-> (upd_nxt <= upd_cur) && (upd_nxt != 2'b11));

  // R10: update stream always ready out of reset
  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> upd_ready);

endmodule

bind gl_hist_predictor gl_hist_predictor_chk #(.G(GHIST_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .upd_valid (upd_valid),
  .upd_ready (upd_ready),
  .upd_taken (upd_taken),
  .ghist     (ghist_q),
  .upd_cur   (upd_ctr_cur),
  .upd_nxt   (upd_ctr_nxt)
);

// File: tb/gl_hist_predictor_test.sv
`timescale 1ns/100ps
module gl_hist_predictor_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 16;
  localparam int G     = 4;
  localparam int P     = 4;
  localparam int E     = 16;
  localparam int ALIGN = 2;
  localparam bit XORM  = 1'b1;
  localparam int LSEL  = $clog2(E);
  localparam int NCTR  = 1 << (G + P);

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rst_n, lk_valid, pred_valid, pred_taken;
  logic          upd_valid, upd_ready, upd_taken;
  logic [AW-1:0] lk_addr, upd_addr;

  gl_hist_predictor #(
    .ADDR_W(AW), .GHIST_W(G), .LHIST_W(P), .LHT_ENTRIES(E),
    .ALIGN_BITS(ALIGN), .XOR_HASH(XORM)
  ) uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .upd_valid(upd_valid),
    .upd_ready(upd_ready), .upd_addr(upd_addr), .upd_taken(upd_taken)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // Arithmetic model state
  logic [G-1:0] m_ghr;
  logic [P-1:0] m_lht [E];
  logic [1:0]   m_pht [NCTR];
  int           loop_cnt [E];

  function automatic int m_idx(input logic [AW-1:0] a);
    logic [G-1:0] gp;
    gp = m_ghr ^ (XORM ? a[ALIGN +: G] : '0);
    return int'({gp, m_lht[a[ALIGN +: LSEL]]});
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ghr = '0;
    for (int i = 0; i < E; i++) begin m_lht[i] = '0; loop_cnt[i] = 0; end
    for (int i = 0; i < NCTR; i++) m_pht[i] = 2'b01;
  endtask

  // Lookup checked against the model (R2, R7)
  task automatic look(input logic [AW-1:0] a, input string req);
    int exp;
    lk_valid = 1'b1;
    lk_addr  = a;
    #1;
    exp = int'(m_pht[m_idx(a)][1]);
    chk(pred_taken == exp, req, int'(pred_taken), exp);
  endtask

  // Lookup checked against a hand-worked value
  task automatic look_fixed(input logic [AW-1:0] a, input bit exp, input string req);
    lk_valid = 1'b1;
    lk_addr  = a;
    #1;
    chk(pred_taken == exp, req, int'(pred_taken), int'(exp));
  endtask

  task automatic model_apply(input logic [AW-1:0] a, input bit t, input int idx);
    int sel;
    sel = int'(a[ALIGN +: LSEL]);
    if (t) m_pht[idx] = (m_pht[idx] == 2'b11) ? 2'b11 : m_pht[idx] + 2'b01;
    else   m_pht[idx] = (m_pht[idx] == 2'b00) ? 2'b00 : m_pht[idx] - 2'b01;
    m_ghr      = {m_ghr[G-2:0], t};
    m_lht[sel] = {m_lht[sel][P-2:0], t};
  endtask

  task automatic upd(input logic [AW-1:0] a, input bit t);
    int idx;
    @(negedge clk);
    upd_valid = 1'b1;
    upd_addr  = a;
    upd_taken = t;
    idx = m_idx(a);          // R8: pre-update histories
    @(posedge clk);
    model_apply(a, t, idx);
    #1 upd_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; lk_addr = '0;
    upd_valid = 1'b0; upd_addr = '0; upd_taken = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: every local register and several hash values predict not-taken
    @(negedge clk);
    chk(upd_ready == 1'b1, "R10 ready", int'(upd_ready), 1);
    for (int i = 0; i < 64; i++) begin
      if (i % 4 == 0) @(negedge clk);
      look_fixed(AW'(i * 4 + (i % 3) * 16'h1000), 1'b0, "R1 reset state");
    end

    // R10: valid follows request, pred_taken quiet when idle
    @(negedge clk);
    lk_valid = 1'b0; #1;
    chk(pred_valid == 1'b0, "R10 pred_valid idle", int'(pred_valid), 0);
    chk(pred_taken == 1'b0, "R2 idle pred", int'(pred_taken), 0);
    lk_valid = 1'b1; #1;
    chk(pred_valid == 1'b1, "R10 pred_valid busy", int'(pred_valid), 1);

    // R3/R8: six taken at address 0; indices 00,11,33,77,FF,FF, so FF reaches 11
    for (int k = 0; k < 6; k++) upd(16'h0000, 1'b1);
    @(negedge clk);
    look_fixed(16'h0000, 1'b1, "R3 trained taken");
    look_fixed(16'h0004, 1'b0, "R7 xor global part 1110 untouched");
    look_fixed(16'h0040, 1'b1, "R6 aliasing local register");
    look(16'h0000, "R3 model agrees");

    // R9: lookup in the update cycle sees the old counter (11 at FF)
    @(negedge clk);
    upd_valid = 1'b1; upd_addr = 16'h0000; upd_taken = 1'b0;
    lk_valid = 1'b1; lk_addr = 16'h0000;
    #1;
    chk(pred_taken == 1'b1, "R9 same-cycle lookup", int'(pred_taken), 1);
    @(posedge clk);
    model_apply(16'h0000, 1'b0, 8'hFF);
    #1 upd_valid = 1'b0;

    // R4/R5: five more not-taken; histories drain to zero, counter 00 ends at 00
    for (int k = 0; k < 5; k++) upd(16'h0000, 1'b0);
    @(negedge clk);
    look_fixed(16'h0000, 1'b0, "R4 trained not-taken");
    look_fixed(16'h0004, 1'b0, "R5 global drained");
    upd(16'h0000, 1'b0);
    @(negedge clk);
    look(16'h0000, "R4 floor");

    // Mixed loop-patterned and random stream against the model
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] a;
      bit t;
      int s;
      a = AW'($urandom);
      a[1:0] = 2'b00;
      s = int'(a[ALIGN +: LSEL]);
      if (s < E/2) begin
        t = (loop_cnt[s] % 4) != 3;     // loop: taken three times, then exit
        loop_cnt[s]++;
      end else begin
        t = 1'($urandom);
      end
      upd(a, t);
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
        logic [AW-1:0] q;
        q = AW'($urandom);
        q[ALIGN +: LSEL] = LSEL'((n * 4 + k) % E);
        look(q, (k % 2 == 0) ? "R2 stream" : "R7 stream");
      end
    end

    // R8 final sweep: each local register under a fixed address
    @(negedge clk);
    for (int i = 0; i < E; i++) begin
      if (i % 4 == 0) @(negedge clk);
      look(AW'(i * 4), "R6 sweep");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule